// File: doc/BRIEF.md
# Event Interrupt Status and Enable Bank

This block collects five interrupt sources and presents them to software through four word-wide registers on a simple synchronous register bus. Four sources come from external wait pins and fire on each low-to-high transition. Each pin is synchronized first, so one transition is counted once. The fifth source is a single-cycle timeout event input from the access engine. Each source has a raw status bit, a masked status bit and an enable bit. A raw bit records every event. A masked bit records only the events that arrive while the source is enabled.

Software enables sources by writing ones to a set register and disables them by writing ones to a clear register. Both registers read back the same enable state. Status is acknowledged by writing ones to either the raw or the masked register, and that write clears both copies of the bit. When a masked bit goes from 0 to 1, the block raises an active-high one-cycle pulse toward the CPU interrupt controller.

Top module: `irq_bank`

## Requirements
- R1: After reset, every status bit and every enable bit is 0 and `irq_o` is low.
- R2: A source event sets its raw status bit whether or not the source is enabled. The bit layout is shared by all four registers: bit 0 is the timeout source and bit 2+k is wait pin k (k = 0..3).
- R3: A masked status bit is set only by an event that arrives while the enable bit of that source is 1. In every other case the masked bit reads 0.
- R4: Writing 1 to a bit of the raw register (offset 0x0) clears that raw bit and the matching masked bit. Writing 0 leaves the bit unchanged.
- R5: Writing 1 to a bit of the masked register (offset 0x4) clears that masked bit and the matching raw bit.
- R6: Writing 1 to the enable-set register (offset 0x8) sets enables. Writing 1 to the enable-clear register (offset 0xC) clears them. Both offsets read the current enable state, and writing 0 has no effect.
- R7: A wait pin event is taken on a rising edge after a two-flop synchronizer. The raw bit is visible three clock edges after the pin rises. A pin held high produces no further events.
- R8: The timeout input sets its raw bit at the clock edge where the input is sampled high.
- R9: Bit 1 and bits 31..6 of all four registers read 0, and writes to those bits change nothing.
- R10: `irq_o` is high for exactly the one cycle in which a masked bit first reads 1 after being 0.
- R11: If an event and a clearing write reach the same bit in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 4 | Wait pins, asynchronous |
| timeout_i | input | 1 | Timeout event, one pulse per event |
| we_i | input | 1 | Register write enable |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt pulse, active high |

## Verification
Reads are combinational. Register writes and timeout pulses take effect at the next clock edge, so the bench checks their results one cycle after it drives them. A wait pin rise passes through two synchronizer flops and an edge register, so the bench checks the raw bit at zero on the first two cycles and sets its expected value only on the third. The interrupt pulse is checked in the same cycle as the masked bit it reports, and again one cycle later, when it must be low. Inputs are driven on the falling edge and a monitor compares each queued expectation a quarter period later, which keeps every comparison clear of the rising edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int WAIT_BASE = 2;  // first wait-source bit; bit 1 reserved

  localparam logic [ADDR_W-1:0] OFS_RAW = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_MSK = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_ENS = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ENC = 4'hC;
endpackage

// File: rtl/wait_edge_det.sv
module wait_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic raw_clr_i,
  input  logic msk_clr_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic raw_o,
  output logic msk_o,
  output logic en_o,
  output logic msk_rise_o
);
  logic raw_q, msk_q, en_q, clr;

  assign clr = raw_clr_i | msk_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      msk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (evt_i)    raw_q <= 1'b1;
      else if (clr) raw_q <= 1'b0;
      if (evt_i && en_q) msk_q <= 1'b1;
      else if (clr)      msk_q <= 1'b0;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
    end
  end

  assign raw_o      = raw_q;
  assign msk_o      = msk_q;
  assign en_o       = en_q;
  assign msk_rise_o = evt_i & en_q & ~msk_q;

  AST_RAW_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> raw_o); // R2
  AST_MSK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msk_o) |-> $past(en_o)); // R3
  AST_MSK_IN_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_o |-> raw_o); // R5
  AST_CLR_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !evt_i) |=> (!raw_o && !msk_o)); // R4
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && evt_i) |=> raw_o); // R11
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int N_WAIT      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WAIT-1:0] wait_i,
  input  logic              timeout_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int N_SRC = N_WAIT + 1;
  localparam int TOP_BIT = WAIT_BASE + N_WAIT;

  function automatic logic [DATA_W-1:0] to_word(input logic [N_SRC-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = v[0];
    for (int k = 1; k < N_SRC; k++) w[WAIT_BASE+k-1] = v[k];
    return w;
  endfunction

  function automatic logic [N_SRC-1:0] from_word(input logic [DATA_W-1:0] w);
    logic [N_SRC-1:0] v;
    v[0] = w[0];
    for (int k = 1; k < N_SRC; k++) v[k] = w[WAIT_BASE+k-1];
    return v;
  endfunction

  logic [N_SRC-1:0] evt, raw, msk, en, rise;
  logic [N_SRC-1:0] wbits, raw_clr, msk_clr, en_set, en_clr;
  logic             irq_q;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:TOP_BIT], wdata_i[1]};

  assign evt[0] = timeout_i;

  for (genvar g = 0; g < N_WAIT; g++) begin : g_wait
    wait_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (wait_i[g]),
      .rise_o(evt[g+1])
    );
  end

  assign wbits   = from_word(wdata_i);
  assign raw_clr = (we_i && addr_i == OFS_RAW) ? wbits : '0;
  assign msk_clr = (we_i && addr_i == OFS_MSK) ? wbits : '0;
  assign en_set  = (we_i && addr_i == OFS_ENS) ? wbits : '0;
  assign en_clr  = (we_i && addr_i == OFS_ENC) ? wbits : '0;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    irq_src_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt[s]),
      .raw_clr_i (raw_clr[s]),
      .msk_clr_i (msk_clr[s]),
      .en_set_i  (en_set[s]),
      .en_clr_i  (en_clr[s]),
      .raw_o     (raw[s]),
      .msk_o     (msk[s]),
      .en_o      (en[s]),
      .msk_rise_o(rise[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |rise;
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (addr_i)
      OFS_RAW: rdata_o = to_word(raw);
      OFS_MSK: rdata_o = to_word(msk);
      OFS_ENS,
      OFS_ENC: rdata_o = to_word(en);
      default: rdata_o = '0;
    endcase
  end

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[1] == 1'b0) && (rdata_o[DATA_W-1:TOP_BIT] == '0)); // R9
  AST_IRQ_FROM_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((msk & ~$past(msk)) != '0)); // R10
  AST_RISE_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((msk & ~$past(msk)) != '0) |-> irq_o); // R10
endmodule

// File: tb/irq_bank_test.sv
module irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam logic [3:0] A_RAW = 4'h0, A_MSK = 4'h4, A_ENS = 4'h8, A_ENC = 4'hC;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    bit          chk_irq;
    logic        exp_irq;
    string       tag;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  wait_pins = '0;
  logic        timeout = 0, we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  item_t q[$];
  int    n_chk = 0, n_fail = 0, wd_cnt = 0;
  bit    wd_hit = 0;

  irq_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .wait_i(wait_pins), .timeout_i(timeout),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt > WD_LIMIT) wd_hit <= 1;
  end

  // monitor: compares one queued expectation per cycle, away from the edge
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (rdata !== it.exp || (it.chk_irq && irq !== it.exp_irq)) begin
        n_fail++;
        $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp_irq=%b",
                 it.tag, it.addr, rdata, it.exp, irq, it.exp_irq);
      end
    end
  end

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string t,
                     input bit ci = 0, input logic ei = 0);
    item_t it;
    @(negedge clk);
    we = 0; addr = a;
    it.addr = a; it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = t;
    q.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic pulse_timeout(input logic [31:0] exp_raw, input logic exp_irq, input string t);
    item_t it;
    @(negedge clk); timeout = 1;
    @(negedge clk); timeout = 0; addr = A_RAW;
    it.addr = A_RAW; it.exp = exp_raw; it.chk_irq = 1; it.exp_irq = exp_irq; it.tag = t;
    q.push_back(it);
  endtask

  task automatic set_waits(input logic [3:0] v);
    @(negedge clk); wait_pins = v;
  endtask

  task automatic stimulus();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(A_RAW, 32'h0, "R1 raw reset", 1, 0);
    chk(A_MSK, 32'h0, "R1 masked reset");
    chk(A_ENS, 32'h0, "R1 enable-set reset");
    chk(A_ENC, 32'h0, "R1 enable-clear reset");
    pulse_timeout(32'h1, 0, "R2 R8 timeout sets raw while disabled");
    chk(A_MSK, 32'h0, "R3 masked stays 0 when disabled");
    wr(A_RAW, 32'h0);
    chk(A_RAW, 32'h1, "R4 write 0 no effect");
    wr(A_RAW, 32'h1);
    chk(A_RAW, 32'h0, "R4 write 1 clears raw");
    wr(A_ENS, 32'h3D);
    chk(A_ENS, 32'h3D, "R6 set reads back");
    chk(A_ENC, 32'h3D, "R6 clear offset reads same");
    wr(A_ENS, 32'hFFFF_FFC2);
    chk(A_ENS, 32'h3D, "R9 reserved enable bits");
    // wait pin 1 -> bit 3, three edges of latency
    set_waits(4'b0010);
    chk(A_RAW, 32'h0, "R7 not yet after edge 1", 1, 0);
    chk(A_RAW, 32'h0, "R7 not yet after edge 2", 1, 0);
    chk(A_RAW, 32'h8, "R7 R10 raw and irq after edge 3", 1, 1);
    chk(A_MSK, 32'h8, "R3 R10 masked set, irq gone", 1, 0);
    wr(A_RAW, 32'h8);
    chk(A_RAW, 32'h0, "R4 raw clear");
    chk(A_MSK, 32'h0, "R4 raw clear also clears masked");
    repeat (4) @(negedge clk);
    chk(A_RAW, 32'h0, "R7 held pin gives no new event");
    pulse_timeout(32'h1, 1, "R10 enabled timeout irq");
    chk(A_MSK, 32'h1, "R3 masked timeout", 1, 0);
    wr(A_MSK, 32'h1);
    chk(A_RAW, 32'h0, "R5 masked clear also clears raw");
    chk(A_MSK, 32'h0, "R5 masked cleared");
    pulse_timeout(32'h1, 1, "R8 timeout again");
    wr(A_RAW, 32'hFFFF_FFC2);
    chk(A_RAW, 32'h1, "R9 reserved raw writes ignored");
    wr(A_MSK, 32'h1);
    wr(A_ENC, 32'h1);
    chk(A_ENS, 32'h3C, "R6 clear via clear register");
    chk(A_ENC, 32'h3C, "R6 clear register reads state");
    wr(A_ENC, 32'h0);
    chk(A_ENC, 32'h3C, "R6 write 0 to clear no effect");
    pulse_timeout(32'h1, 0, "R3 disabled timeout no irq");
    chk(A_MSK, 32'h0, "R3 masked 0 after disable");
    set_waits(4'b0000);
    @(negedge clk); we = 1; addr = A_RAW; wdata = 32'h1; timeout = 1;
    @(negedge clk); we = 0; wdata = '0; timeout = 0;
    chk(A_RAW, 32'h1, "R11 event beats clear");
    wr(A_RAW, 32'h1);
    chk(A_RAW, 32'h0, "R4 clear after priority case");
    set_waits(4'b1001);
    chk(A_RAW, 32'h0, "R7 two pins edge 1", 1, 0);
    chk(A_RAW, 32'h0, "R7 two pins edge 2", 1, 0);
    chk(A_RAW, 32'h24, "R2 R7 pins 0 and 3 map to bits 2 and 5", 1, 1);
    chk(A_MSK, 32'h24, "R3 both masked", 1, 0);
    wr(A_MSK, 32'h24);
    chk(A_RAW, 32'h0, "R5 multi clear");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      wait (wd_hit);
    join_any
    if (wd_hit) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule